// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Scheduler

This block lives inside an SDRAM controller and runs one read burst at a time. It accepts a read request carrying a bank, a starting column, the number of data beats the requester wants, a burst mode (fixed length or full page) and a request to close the row afterwards. It then drives the command bus with a READ, a run of NOPs and, where the burst must end early or the row must be closed, a single BURST TERMINATE or PRECHARGE. A data-valid strobe marks exactly the wanted beats.

The ending command is always placed CL−1 cycles ahead of the last wanted beat. Counted from the READ cycle, this lands in cycle N for a burst of N beats on the bus, for either CAS latency. Closing the row always uses an explicit PRECHARGE, so truncated and full-length bursts share one path. After a PRECHARGE, a per-bank timer holds that bank closed to new requests for the row-precharge time, while other banks stay open.

Top module: `rd_trunc_sched`

## Requirements
- R1: During reset and in the first cycle after it, the command bus carries NOP (code 0) and rd_valid is low. With reset released and no burst running, req_ready is high for every bank.
- R2: A request accepted at a clock edge (req_valid and req_ready both high) puts READ (code 1) on the command bus in the next cycle, with the request's bank and column. The CAS latency is 2 when cl_sel is 0 and 3 when cl_sel is 1.
- R3: rd_valid is high in exactly the cycles READ+CL through READ+CL+W−1, where W is the wanted beat count. A wanted count of 0 counts as 1. In fixed-length mode W is limited to FIXED_LEN.
- R4: Without a close request, BURST TERMINATE (code 2) appears once, in cycle READ+N. This holds for any full-page burst of N beats. It also holds for a fixed-length burst with CL−1 ≤ N < FIXED_LEN.
- R5: With a close request, a burst that R4 would truncate gets PRECHARGE (code 3) in the same cycle instead of BURST TERMINATE.
- R6: A fixed-length burst with N ≥ FIXED_LEN and no close request runs to its end with no ending command: only NOPs follow the READ.
- R7: A fixed-length burst with N ≥ FIXED_LEN and a close request gets PRECHARGE in cycle READ+FIXED_LEN, which is CL−1 cycles ahead of its last beat.
- R8: A fixed-length request with N < CL−1 is not truncated. The full burst runs, with PRECHARGE in cycle READ+FIXED_LEN only when a close was requested, and rd_valid still covers only the N wanted beats.
- R9: req_ready is low from the READ cycle through the last bus beat (READ+CL+L−1, where L is the number of beats on the bus). It rises in the next cycle when the bank is free. rd_valid is never high while req_ready is high.
- R10: After a PRECHARGE to bank b in cycle P, req_ready stays low for requests to b until cycle P+T_RP−1. The next READ to b therefore comes no earlier than P+T_RP. Other banks are not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_sel | input | 1 | Static CAS latency select: 0 = 2 cycles, 1 = 3 cycles |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_beats | input | BEAT_W | Wanted beat count |
| req_full_page | input | 1 | 1 = full-page burst, 0 = fixed length |
| req_auto_pre | input | 1 | Close the row after the burst |
| cmd_code | output | 3 | Command: 0 NOP, 1 READ, 2 BURST TERMINATE, 3 PRECHARGE |
| cmd_bank | output | BANK_W | Bank of the command on the bus |
| cmd_col | output | COL_W | Column of the READ |
| rd_valid | output | 1 | This cycle carries a wanted data beat |

## Verification
Every result is timed from the READ, which appears one cycle after the accepting edge. Beat k is due in READ+CL+k. The ending command is due in READ+N. req_ready returns in READ+CL+L, or for the same bank after a PRECHARGE in cycle P, in P+T_RP−1. The bench waits for the accepting edge, then samples every output on each falling edge of a fixed window and compares it, cycle by cycle, with a value computed from these offsets. A directed case then issues a request to the held bank and measures the gap from PRECHARGE to the next READ.

// File: rtl/rdtrunc_pkg.sv
package rdtrunc_pkg;

    localparam int SEQ_W = 12;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_READ = 3'd1,
        CMD_BST  = 3'd2,
        CMD_PRE  = 3'd3
    } sdr_cmd_e;

    typedef struct packed {
        logic [SEQ_W-1:0] lat;       // CAS latency in cycles
        logic [SEQ_W-1:0] stop_at;   // cycle index of ending command (= beats on bus)
        logic [SEQ_W-1:0] vld_end;   // first cycle index past the wanted data
        logic [SEQ_W-1:0] last_at;   // cycle index of last beat on the bus
        sdr_cmd_e         stop_cmd;  // NOP when no ending command is sent
    } burst_plan_t;

    function automatic logic [SEQ_W-1:0] cas_cycles(input logic cl3);
        return cl3 ? SEQ_W'(3) : SEQ_W'(2);
    endfunction

    function automatic logic [SEQ_W-1:0] norm_beats(input logic [SEQ_W-1:0] b);
        return (b == '0) ? SEQ_W'(1) : b;
    endfunction

endpackage

// File: rtl/rdtrunc_planner.sv
module rdtrunc_planner
    import rdtrunc_pkg::*;
#(
    parameter int BEAT_W    = 9,
    parameter int FIXED_LEN = 4
) (
    input  logic              cl3,
    input  logic [BEAT_W-1:0] beats,
    input  logic              full_page,
    input  logic              auto_pre,
    output burst_plan_t       plan
);

    localparam logic [SEQ_W-1:0] FL = SEQ_W'(FIXED_LEN);

    logic [SEQ_W-1:0] lat;
    logic [SEQ_W-1:0] want;
    logic [SEQ_W-1:0] bus_len;
    logic [SEQ_W-1:0] keep;
    sdr_cmd_e         stop;

    always_comb begin
        lat  = cas_cycles(cl3);
        want = norm_beats({{(SEQ_W-BEAT_W){1'b0}}, beats});
        stop = auto_pre ? CMD_PRE : CMD_BST;
        if (full_page) begin
            bus_len = want;
            keep    = want;
        end else if (want >= FL) begin
            bus_len = FL;
            keep    = FL;
            if (!auto_pre) stop = CMD_NOP;
        end else if (want < lat - SEQ_W'(1)) begin
            bus_len = FL;
            keep    = want;
            if (!auto_pre) stop = CMD_NOP;
        end else begin
            bus_len = want;
            keep    = want;
        end
        plan.lat      = lat;
        plan.stop_at  = bus_len;
        plan.vld_end  = lat + keep;
        plan.last_at  = lat + bus_len - SEQ_W'(1);
        plan.stop_cmd = stop;
    end

endmodule

// File: rtl/rdtrunc_sequencer.sv
module rdtrunc_sequencer
    import rdtrunc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_ap,
    input  burst_plan_t       start_plan,
    output logic              active,
    output sdr_cmd_e          cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              rd_valid
);

    burst_plan_t      plan_q;
    logic [SEQ_W-1:0] cnt;
    logic [SEQ_W-1:0] nxt;
    logic             ap_q;
    sdr_cmd_e         cmd_nxt;
    logic             rdv_nxt;

    always_comb begin
        nxt     = cnt + SEQ_W'(1);
        cmd_nxt = (plan_q.stop_cmd != CMD_NOP && nxt == plan_q.stop_at)
                  ? plan_q.stop_cmd : CMD_NOP;
        rdv_nxt = (nxt >= plan_q.lat) && (nxt < plan_q.vld_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            plan_q   <= '0;
            ap_q     <= 1'b0;
            cmd      <= CMD_NOP;
            cmd_bank <= '0;
            cmd_col  <= '0;
            rd_valid <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            cnt      <= '0;
            plan_q   <= start_plan;
            ap_q     <= start_ap;
            cmd      <= CMD_READ;
            cmd_bank <= start_bank;
            cmd_col  <= start_col;
            rd_valid <= 1'b0;
        end else if (active) begin
            if (cnt == plan_q.last_at) begin
                active   <= 1'b0;
                cmd      <= CMD_NOP;
                rd_valid <= 1'b0;
            end else begin
                cnt      <= nxt;
                cmd      <= cmd_nxt;
                rd_valid <= rdv_nxt;
            end
        end else begin
            cmd      <= CMD_NOP;
            rd_valid <= 1'b0;
        end
    end

    AST_READ_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> cmd == CMD_READ);  // R2

    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BST || cmd == CMD_PRE) |=> !(cmd == CMD_BST || cmd == CMD_PRE));  // R4

    AST_PRE_ONLY_WITH_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> ap_q);  // R5

    AST_DATA_INSIDE_BURST: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> active);  // R9

endmodule

// File: rtl/rdtrunc_bank_recovery.sv
module rdtrunc_bank_recovery
    import rdtrunc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int T_RP      = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sdr_cmd_e             cmd,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] bank_busy
);

    localparam int TMR_W = $clog2(T_RP + 1);
    localparam logic [TMR_W-1:0] LOAD = (T_RP >= 2) ? TMR_W'(T_RP - 2) : '0;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [TMR_W-1:0] tmr;
        always_ff @(posedge clk) begin
            if (rst) begin
                tmr <= '0;
            end else if (cmd == CMD_PRE && cmd_bank == BANK_W'(b)) begin
                tmr <= LOAD;
            end else if (tmr != '0) begin
                tmr <= tmr - TMR_W'(1);
            end
        end
        assign bank_busy[b] = (tmr != '0);
    end

    AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && T_RP > 2) |=> bank_busy[$past(cmd_bank)]);  // R10

endmodule

// File: rtl/rd_trunc_sched.sv
module rd_trunc_sched
    import rdtrunc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 8,
    parameter int BEAT_W    = 9,
    parameter int FIXED_LEN = 4,
    parameter int T_RP      = 5,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cl_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              req_full_page,
    input  logic              req_auto_pre,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              rd_valid
);

    burst_plan_t          plan;
    logic                 seq_active;
    logic                 start;
    sdr_cmd_e             seq_cmd;
    logic [NUM_BANKS-1:0] bank_busy;

    rdtrunc_planner #(
        .BEAT_W    (BEAT_W),
        .FIXED_LEN (FIXED_LEN)
    ) u_plan (
        .cl3       (cl_sel),
        .beats     (req_beats),
        .full_page (req_full_page),
        .auto_pre  (req_auto_pre),
        .plan      (plan)
    );

    assign req_ready = !rst && !seq_active && !bank_busy[req_bank];
    assign start     = req_valid && req_ready;

    rdtrunc_sequencer #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_bank (req_bank),
        .start_col  (req_col),
        .start_ap   (req_auto_pre),
        .start_plan (plan),
        .active     (seq_active),
        .cmd        (seq_cmd),
        .cmd_bank   (cmd_bank),
        .cmd_col    (cmd_col),
        .rd_valid   (rd_valid)
    );

    rdtrunc_bank_recovery #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .T_RP      (T_RP)
    ) u_rec (
        .clk       (clk),
        .rst       (rst),
        .cmd       (seq_cmd),
        .cmd_bank  (cmd_bank),
        .bank_busy (bank_busy)
    );

    assign cmd_code = seq_cmd;

    AST_READ_BANK_FREE: assert property (@(posedge clk) disable iff (rst)
        (seq_cmd == CMD_READ) |-> !bank_busy[cmd_bank]);  // R10

    AST_NO_DATA_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rd_valid);  // R9

endmodule

// File: tb/sim_rd_trunc_sched.sv
`timescale 1ns/1ps
module sim_rd_trunc_sched;

    localparam int FIXED = 4;
    localparam int TRP   = 5;
    localparam int W     = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cl_sel = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [7:0] req_col = '0;
    logic [8:0] req_beats = 9'd1;
    logic       req_full_page = 1'b0;
    logic       req_auto_pre = 1'b0;
    logic [2:0] cmd_code;
    logic [1:0] cmd_bank;
    logic [7:0] cmd_col;
    logic       rd_valid;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rd_trunc_sched u0 (
        .clk(clk), .rst(rst), .cl_sel(cl_sel),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_col(req_col), .req_beats(req_beats),
        .req_full_page(req_full_page), .req_auto_pre(req_auto_pre),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic       cl3;
        logic       fp;
        logic       ap;
        logic [8:0] beats;
        logic [2:0] tcmd;   // expected ending command, 0 = none
        logic [5:0] tat;    // cycle after READ carrying it
        logic [5:0] nb;     // expected valid beats
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{4'd6, 1'b0, 1'b0, 1'b0, 9'd4,  3'd0, 6'd0,  6'd4 },  // R6
        '{4'd4, 1'b1, 1'b0, 1'b0, 9'd2,  3'd2, 6'd2,  6'd2 },  // R4 fixed, CL3
        '{4'd4, 1'b0, 1'b0, 1'b0, 9'd1,  3'd2, 6'd1,  6'd1 },  // R4 fixed, CL2
        '{4'd8, 1'b1, 1'b0, 1'b0, 9'd1,  3'd0, 6'd0,  6'd1 },  // R8 masked
        '{4'd8, 1'b1, 1'b0, 1'b1, 9'd1,  3'd3, 6'd4,  6'd1 },  // R8 masked + close
        '{4'd5, 1'b0, 1'b0, 1'b1, 9'd3,  3'd3, 6'd3,  6'd3 },  // R5 fixed
        '{4'd7, 1'b1, 1'b0, 1'b1, 9'd9,  3'd3, 6'd4,  6'd4 },  // R7, R3 clamp
        '{4'd4, 1'b0, 1'b1, 1'b0, 9'd10, 3'd2, 6'd10, 6'd10},  // R4 full page
        '{4'd5, 1'b1, 1'b1, 1'b1, 9'd6,  3'd3, 6'd6,  6'd6 },  // R5 full page
        '{4'd4, 1'b1, 1'b1, 1'b0, 9'd1,  3'd2, 6'd1,  6'd1 },  // R4 full page short
        '{4'd3, 1'b0, 1'b0, 1'b0, 9'd0,  3'd2, 6'd1,  6'd1 }   // R3 zero count
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v = VEC[i];
        int lat = v.cl3 ? 3 : 2;
        int len = (v.tcmd != 3'd0) ? int'(v.tat) : FIXED;
        logic [1:0] bk = 2'(i % 4);
        logic [7:0] cl = 8'(i * 7 + 3);
        int cbad = 0, ca = 0, ce = 0;
        int rbad = 0, ra = 0, re = 0;
        int ybad = 0, ya = 0, ye = 0;
        cl_sel = v.cl3; req_full_page = v.fp; req_auto_pre = v.ap;
        req_beats = v.beats; req_bank = bk; req_col = cl; req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int t = 0; t < W; t++) begin
            int ec, er, ey;
            @(negedge clk);
            ec = (t == 0) ? 1 : ((v.tcmd != 3'd0 && t == int'(v.tat)) ? int'(v.tcmd) : 0);
            er = (t >= lat && t < lat + int'(v.nb)) ? 1 : 0;
            ey = (t >= lat + len && !(v.tcmd == 3'd3 && t < int'(v.tat) + TRP - 1)) ? 1 : 0;
            if (int'(cmd_code) != ec || (t == 0 && (cmd_bank !== bk || cmd_col !== cl))) begin
                if (cbad == 0) begin ca = int'(cmd_code); ce = ec; end
                cbad++;
            end
            if (int'(rd_valid) != er) begin
                if (rbad == 0) begin ra = int'(rd_valid); re = er; end
                rbad++;
            end
            if (int'(req_ready) != ey) begin
                if (ybad == 0) begin ya = int'(req_ready); ye = ey; end
                ybad++;
            end
        end
        check(cbad == 0, $sformatf("R%0d/R2", v.rq), $sformatf("vec %0d command", i), ca, ce);
        check(rbad == 0, "R3", $sformatf("vec %0d rd_valid", i), ra, re);
        check(ybad == 0, (v.tcmd == 3'd3) ? "R10" : "R9", $sformatf("vec %0d req_ready", i), ya, ye);
    endtask

    initial begin
        #1_000_000;
        total++;
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int pre_t;
        int rd_t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_code == 3'd0 && rd_valid == 1'b0, "R1", "in reset", int'(cmd_code), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(cmd_code == 3'd0, "R1", "cmd after reset", int'(cmd_code), 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        for (int i = 0; i < 11; i++) run_vec(i);

        // R10: other bank free, same bank held, READ spacing from PRECHARGE
        cl_sel = 1'b0; req_full_page = 1'b0; req_auto_pre = 1'b1;
        req_beats = 9'd2; req_bank = 2'd1; req_col = 8'd5; req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        pre_t = -1;
        rd_t  = -1;
        for (int t = 0; t < W; t++) begin
            @(negedge clk);
            if (cmd_code == 3'd3 && pre_t < 0) pre_t = t;
            if (cmd_code == 3'd1 && t > 0 && rd_t < 0) begin
                rd_t = t;
                req_valid = 1'b0;
            end
            if (t == 4) begin
                req_bank = 2'd2;
                #1 check(req_ready == 1'b1, "R10", "other bank open", int'(req_ready), 1);
                req_bank = 2'd1;
                #1 check(req_ready == 1'b0, "R10", "same bank held", int'(req_ready), 0);
                req_beats = 9'd4; req_auto_pre = 1'b0; req_valid = 1'b1;
            end
        end
        req_valid = 1'b0;
        check(pre_t == 2, "R5", "precharge cycle", pre_t, 2);
        check(rd_t - pre_t == TRP, "R10", "PRE to READ gap", rd_t - pre_t, TRP);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule